// File: doc/BRIEF.md
# Registered Eight-Bit ALU with Status Flags

This block is the arithmetic and logic stage of a small 8-bit audio-processor core. A one-cycle start pulse captures an operation code, a destination byte, a source byte, a 16-bit register pair made of a high byte Y and a low byte A, and the incoming status byte. One cycle later the block presents the result with a valid strobe. The result is a low byte plus a high byte for word, multiply and divide operations. It also presents the updated status byte and a divide-error flag.

The block covers byte add and subtract with carry, compare, the three bitwise logic operations, shifts, rotates in both directions, nibble swap, and increment and decrement. On the register pair it covers word add, subtract and compare against the word {src, dst}, word increment and decrement, and 8x8 multiply and divide of A by src. Subtraction treats carry as an inverted borrow, so C = 1 means no borrow occurred. Instruction fetch, addressing and memory sit outside the block.

The status byte is packed N V P B H I Z C from bit 7 down to bit 0. Bits P (5), B (4) and I (2) pass from psw_in to psw_out unchanged on every operation. Operation codes that are not listed below return dst in res_lo and zero in res_hi, and leave all flags as they came in.

Top module: `alu8_core`

## Requirements
- R1: Code 0 (add with carry) returns dst+src+C in DW bits. C is the carry out of bit DW-1. V is the MSB of (dst^sum)&(src^sum). H is bit DW/2 of dst^src^sum. N and Z come from the result.
- R2: Code 1 (subtract with borrow) returns dst-src-(1-C). C=1 when no borrow occurred. V is the MSB of (dst^diff)&(dst^src). H is bit DW/2 of dst^src^diff. N and Z come from the result.
- R3: Code 2 (compare) sets N and Z from dst-src, and sets C=1 when no borrow occurred. V and H keep their input values. res_lo returns dst unchanged and res_hi returns 0.
- R4: Codes 3, 4 and 5 (AND, OR, XOR of dst with src) set only N and Z. C, V and H keep their input values.
- R5: All four shift codes operate on dst and leave V and H unchanged. Code 6 shifts left and moves the MSB into C. Code 7 shifts right logically and moves bit 0 into C. Code 8 rotates left, bringing the old C into bit 0 and moving the MSB to C. Code 9 rotates right, bringing the old C into the MSB and moving bit 0 to C.
- R6: Code 10 swaps the upper and lower halves of dst and sets N and Z from the swapped value. C, V and H are unchanged.
- R7: Codes 11 and 12 increment and decrement dst with wrap-around, and update only N and Z.
- R8: Codes 13, 14 and 15 add, subtract and compare the word operand {src,dst} against the pair over 2*DW bits. C is the carry out of the top bit, or no-borrow for codes 14 and 15. V uses the same XOR form as R1 and R2, taken at the top bit; code 15 leaves V unchanged. Z means the whole word is zero, N is the top bit, and H is unchanged. Codes 13 and 14 return the word result in {res_hi,res_lo}; code 15 returns the pair unchanged.
- R9: Codes 16 and 17 increment and decrement the pair across 2*DW bits and update only N and Z from the full word.
- R10: Code 18 multiplies A by src and returns the product with the low half in res_lo and the high half in res_hi. Z and N come from the full product, N from its top bit, and C, V and H are unchanged.
- R11: Code 19 divides A by src, returning the quotient in res_lo and the remainder in res_hi. N and Z come from the quotient, and C, V and H are unchanged. When src is zero, res_lo returns A, res_hi returns Y, psw_out equals psw_in and div_err is 1. div_err is 0 for every other case.
- R12: valid is 1 in exactly the cycle after a cycle with start high, and 0 otherwise. While start is low, res_lo, res_hi, psw_out and div_err hold their values.
- R13: psw_out bits 5, 4 and 2 equal the corresponding bits of psw_in.
- R14: After reset, valid, res_lo, res_hi, psw_out and div_err are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Captures the operands and the operation this cycle |
| op | input | 5 | Operation code |
| dst | input | DW | Destination byte, and the low half of the word operand |
| src | input | DW | Source byte, the high half of the word operand, and the multiplier or divisor |
| pair | input | 2*DW | Register pair, Y in the high half and A in the low half |
| psw_in | input | 8 | Incoming status byte, N V P B H I Z C |
| valid | output | 1 | Result is valid |
| res_lo | output | DW | Low result byte: the byte result, or A or the quotient |
| res_hi | output | DW | High result byte: Y, or the remainder, or the product high half |
| psw_out | output | 8 | Updated status byte |
| div_err | output | 1 | Divide by zero occurred |

## Verification
The bench builds two copies of the block. The first uses the default DW=8 and runs a table of hand-worked vectors, random operands for every operation, and the directed reset, handshake and flag pass-through tests. The second uses DW=4, which shrinks the byte space to 16 values. This makes every operand pair with both carry values affordable for all byte operations, multiply and divide, including every divide-by-zero case and every half-carry and overflow boundary. The reference model is written for any width, so the same model checks both copies.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [4:0] {
    OP_ADC  = 5'd0,
    OP_SBC  = 5'd1,
    OP_CMP  = 5'd2,
    OP_AND  = 5'd3,
    OP_OR   = 5'd4,
    OP_XOR  = 5'd5,
    OP_ASL  = 5'd6,
    OP_LSR  = 5'd7,
    OP_ROL  = 5'd8,
    OP_ROR  = 5'd9,
    OP_XCN  = 5'd10,
    OP_INC  = 5'd11,
    OP_DEC  = 5'd12,
    OP_ADDW = 5'd13,
    OP_SUBW = 5'd14,
    OP_CMPW = 5'd15,
    OP_INCW = 5'd16,
    OP_DECW = 5'd17,
    OP_MUL  = 5'd18,
    OP_DIV  = 5'd19
  } alu_op_e;

  // Status byte bit positions; neighbouring logic decodes these.
  localparam int PSW_N = 7;
  localparam int PSW_V = 6;
  localparam int PSW_P = 5;
  localparam int PSW_B = 4;
  localparam int PSW_H = 3;
  localparam int PSW_I = 2;
  localparam int PSW_Z = 1;
  localparam int PSW_C = 0;

endpackage

// File: rtl/alu8_byte_unit.sv
module alu8_byte_unit
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [4:0]    op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  output logic [DW-1:0] res,
  output logic          n_o,
  output logic          z_o,
  output logic          c_o,
  output logic          v_o,
  output logic          h_o,
  output logic          upd_nz,
  output logic          upd_c,
  output logic          upd_vh
);
  localparam int HB = DW / 2;

  logic [DW:0]   sum, dif, cmpd;
  logic [DW-1:0] fsrc;
  logic          v_add, h_add, v_sub, h_sub;

  assign sum  = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
  assign dif  = {1'b0, a} - {1'b0, b} - {{DW{1'b0}}, ~cin};
  assign cmpd = {1'b0, a} - {1'b0, b};

  assign v_add = (a[DW-1] ^ sum[DW-1]) & (b[DW-1] ^ sum[DW-1]);
  assign h_add = a[HB] ^ b[HB] ^ sum[HB];
  assign v_sub = (a[DW-1] ^ dif[DW-1]) & (a[DW-1] ^ b[DW-1]);
  assign h_sub = a[HB] ^ b[HB] ^ dif[HB];

  always_comb begin
    res    = a;
    fsrc   = a;
    c_o    = cin;
    v_o    = 1'b0;
    h_o    = 1'b0;
    upd_nz = 1'b1;
    upd_c  = 1'b0;
    upd_vh = 1'b0;
    case (op)
      OP_ADC: begin
        res = sum[DW-1:0]; c_o = sum[DW]; v_o = v_add; h_o = h_add;
        upd_c = 1'b1; upd_vh = 1'b1;
      end
      OP_SBC: begin
        res = dif[DW-1:0]; c_o = ~dif[DW]; v_o = v_sub; h_o = h_sub;
        upd_c = 1'b1; upd_vh = 1'b1;
      end
      OP_CMP: begin
        fsrc = cmpd[DW-1:0]; c_o = ~cmpd[DW]; upd_c = 1'b1;
      end
      OP_AND: res = a & b;
      OP_OR:  res = a | b;
      OP_XOR: res = a ^ b;
      OP_ASL: begin res = {a[DW-2:0], 1'b0}; c_o = a[DW-1]; upd_c = 1'b1; end
      OP_LSR: begin res = {1'b0, a[DW-1:1]}; c_o = a[0];    upd_c = 1'b1; end
      OP_ROL: begin res = {a[DW-2:0], cin};  c_o = a[DW-1]; upd_c = 1'b1; end
      OP_ROR: begin res = {cin, a[DW-1:1]};  c_o = a[0];    upd_c = 1'b1; end
      OP_XCN: res = {a[HB-1:0], a[DW-1:HB]};
      OP_INC: res = a + DW'(1);
      OP_DEC: res = a - DW'(1);
      default: upd_nz = 1'b0;
    endcase
    if (op != OP_CMP) fsrc = res;
  end

  assign n_o = fsrc[DW-1];
  assign z_o = (fsrc == '0);

endmodule

// File: rtl/alu8_word_unit.sv
module alu8_word_unit
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [4:0]      op,
  input  logic [2*DW-1:0] pair,
  input  logic [2*DW-1:0] opw,
  input  logic [DW-1:0]   b,
  input  logic            cin,
  output logic [2*DW-1:0] res,
  output logic            n_o,
  output logic            z_o,
  output logic            c_o,
  output logic            v_o,
  output logic            upd_nz,
  output logic            upd_c,
  output logic            upd_v,
  output logic            err
);
  localparam int WW = 2 * DW;

  logic [WW:0]   wsum, wdif;
  logic [WW-1:0] prod, fsrc;
  logic [DW-1:0] divisor, quo, rem;
  logic          div_zero, byte_nz;

  assign wsum     = {1'b0, pair} + {1'b0, opw};
  assign wdif     = {1'b0, pair} - {1'b0, opw};
  assign prod     = WW'(pair[DW-1:0]) * WW'(b);
  assign div_zero = (b == '0);
  // Substitute divisor keeps the divider free of X when b is zero.
  assign divisor  = div_zero ? DW'(1) : b;
  assign quo      = pair[DW-1:0] / divisor;
  assign rem      = pair[DW-1:0] % divisor;

  always_comb begin
    res     = pair;
    fsrc    = pair;
    c_o     = cin;
    v_o     = 1'b0;
    upd_nz  = 1'b1;
    upd_c   = 1'b0;
    upd_v   = 1'b0;
    err     = 1'b0;
    byte_nz = 1'b0;
    case (op)
      OP_ADDW: begin
        res = wsum[WW-1:0]; c_o = wsum[WW];
        v_o = (pair[WW-1] ^ wsum[WW-1]) & (opw[WW-1] ^ wsum[WW-1]);
        upd_c = 1'b1; upd_v = 1'b1;
      end
      OP_SUBW: begin
        res = wdif[WW-1:0]; c_o = ~wdif[WW];
        v_o = (pair[WW-1] ^ wdif[WW-1]) & (pair[WW-1] ^ opw[WW-1]);
        upd_c = 1'b1; upd_v = 1'b1;
      end
      OP_CMPW: begin fsrc = wdif[WW-1:0]; c_o = ~wdif[WW]; upd_c = 1'b1; end
      OP_INCW: res = pair + WW'(1);
      OP_DECW: res = pair - WW'(1);
      OP_MUL:  res = prod;
      OP_DIV: begin
        if (div_zero) begin
          err = 1'b1; upd_nz = 1'b0;
        end else begin
          res = {rem, quo}; byte_nz = 1'b1;
        end
      end
      default: upd_nz = 1'b0;
    endcase
    if (op != OP_CMPW) fsrc = res;
  end

  assign n_o = byte_nz ? quo[DW-1] : fsrc[WW-1];
  assign z_o = byte_nz ? (quo == '0) : (fsrc == '0);

endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [4:0]      op,
  input  logic [DW-1:0]   dst,
  input  logic [DW-1:0]   src,
  input  logic [2*DW-1:0] pair,
  input  logic [7:0]      psw_in,
  output logic            valid,
  output logic [DW-1:0]   res_lo,
  output logic [DW-1:0]   res_hi,
  output logic [7:0]      psw_out,
  output logic            div_err
);
  localparam int WW = 2 * DW;

  logic [DW-1:0] b_res;
  logic          b_n, b_z, b_c, b_v, b_h, b_unz, b_uc, b_uvh;
  logic [WW-1:0] w_res;
  logic          w_n, w_z, w_c, w_v, w_unz, w_uc, w_uv, w_err;
  logic          word_sel;

  logic [DW-1:0] lo_nx, hi_nx, lo_q, hi_q;
  logic [7:0]    psw_nx, psw_q;
  logic          err_nx, err_q, valid_q;

  alu8_byte_unit #(.DW(DW)) u_byte (
    .op(op), .a(dst), .b(src), .cin(psw_in[PSW_C]), .res(b_res),
    .n_o(b_n), .z_o(b_z), .c_o(b_c), .v_o(b_v), .h_o(b_h),
    .upd_nz(b_unz), .upd_c(b_uc), .upd_vh(b_uvh)
  );

  alu8_word_unit #(.DW(DW)) u_word (
    .op(op), .pair(pair), .opw({src, dst}), .b(src), .cin(psw_in[PSW_C]),
    .res(w_res), .n_o(w_n), .z_o(w_z), .c_o(w_c), .v_o(w_v),
    .upd_nz(w_unz), .upd_c(w_uc), .upd_v(w_uv), .err(w_err)
  );

  assign word_sel = (op >= OP_ADDW) && (op <= OP_DIV);

  // Next-state: choose a unit, then merge its flag updates into the status byte.
  always_comb begin
    psw_nx = psw_in;
    if (word_sel) begin
      lo_nx  = w_res[DW-1:0];
      hi_nx  = w_res[WW-1:DW];
      err_nx = w_err;
      if (w_unz) begin psw_nx[PSW_N] = w_n; psw_nx[PSW_Z] = w_z; end
      if (w_uc)  psw_nx[PSW_C] = w_c;
      if (w_uv)  psw_nx[PSW_V] = w_v;
    end else begin
      lo_nx  = b_res;
      hi_nx  = '0;
      err_nx = 1'b0;
      if (b_unz) begin psw_nx[PSW_N] = b_n; psw_nx[PSW_Z] = b_z; end
      if (b_uc)  psw_nx[PSW_C] = b_c;
      if (b_uvh) begin psw_nx[PSW_V] = b_v; psw_nx[PSW_H] = b_h; end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      lo_q    <= '0;
      hi_q    <= '0;
      psw_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= start;
      if (start) begin
        lo_q  <= lo_nx;
        hi_q  <= hi_nx;
        psw_q <= psw_nx;
        err_q <= err_nx;
      end
    end
  end

  assign valid   = valid_q;
  assign res_lo  = lo_q;
  assign res_hi  = hi_q;
  assign psw_out = psw_q;
  assign div_err = err_q;

endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [4:0]    op,
  input logic [DW-1:0] dst,
  input logic [DW-1:0] src,
  input logic [7:0]    psw_in,
  input logic          valid,
  input logic [DW-1:0] res_lo,
  input logic [DW-1:0] res_hi,
  input logic [7:0]    psw_out,
  input logic          div_err
);

  AST_VALID_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> valid); // R12

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !valid); // R12

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(res_lo) && $stable(res_hi) && $stable(psw_out) && $stable(div_err))); // R12

  AST_PBI_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (psw_out[PSW_P] == $past(psw_in[PSW_P]) && psw_out[PSW_B] == $past(psw_in[PSW_B])
               && psw_out[PSW_I] == $past(psw_in[PSW_I]))); // R13

  AST_CMP_KEEPS_DST: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op == OP_CMP) |=> (res_lo == $past(dst) && res_hi == '0)); // R3

  AST_LOGIC_KEEPS_CVH: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op inside {OP_AND, OP_OR, OP_XOR}) |=>
      (psw_out[PSW_C] == $past(psw_in[PSW_C]) && psw_out[PSW_V] == $past(psw_in[PSW_V])
       && psw_out[PSW_H] == $past(psw_in[PSW_H]))); // R4

  AST_INCDEC_KEEPS_CVH: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op inside {OP_INC, OP_DEC}) |=>
      (psw_out[PSW_C] == $past(psw_in[PSW_C]) && psw_out[PSW_V] == $past(psw_in[PSW_V])
       && psw_out[PSW_H] == $past(psw_in[PSW_H]))); // R7

  AST_DIV_ZERO_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op == OP_DIV && src == '0) |=> (div_err && psw_out == $past(psw_in))); // R11

  AST_ERR_ONLY_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !(op == OP_DIV && src == '0)) |=> !div_err); // R11

endmodule

bind alu8_core alu8_core_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .op(op), .dst(dst), .src(src),
  .psw_in(psw_in), .valid(valid), .res_lo(res_lo), .res_hi(res_hi),
  .psw_out(psw_out), .div_err(div_err)
);

// File: tb/alu8_core_tb.sv
module alu8_core_tb;

  logic clk, rst_n;
  int   checks = 0;
  int   fails  = 0;

  // Wide copy (DW=8)
  logic        st8;
  logic [4:0]  op8;
  logic [7:0]  d8, s8, f8;
  logic [15:0] pr8;
  logic        v8, e8;
  logic [7:0]  lo8, hi8, p8;

  // Narrow copy (DW=4)
  logic        st4;
  logic [4:0]  op4;
  logic [3:0]  d4, s4;
  logic [7:0]  pr4, f4;
  logic        v4, e4;
  logic [3:0]  lo4, hi4;
  logic [7:0]  p4;

  alu8_core #(.DW(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(st8), .op(op8), .dst(d8), .src(s8),
    .pair(pr8), .psw_in(f8), .valid(v8), .res_lo(lo8), .res_hi(hi8),
    .psw_out(p8), .div_err(e8)
  );

  alu8_core #(.DW(4)) u_dut_n4 (
    .clk(clk), .rst_n(rst_n), .start(st4), .op(op4), .dst(d4), .src(s4),
    .pair(pr4), .psw_in(f4), .valid(v4), .res_lo(lo4), .res_hi(hi4),
    .psw_out(p4), .div_err(e4)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {op, dst, src, pair, psw_in, exp_lo, exp_hi, exp_psw, exp_err}
  localparam int NV = 18;
  localparam logic [69:0] VEC [NV] = '{
    {5'd0,  8'h7F, 8'h01, 16'h0000, 8'h00, 8'h80, 8'h00, 8'hC8, 1'b0},
    {5'd0,  8'hFF, 8'h00, 16'h0000, 8'h01, 8'h00, 8'h00, 8'h0B, 1'b0},
    {5'd1,  8'h00, 8'h01, 16'h0000, 8'h01, 8'hFF, 8'h00, 8'h88, 1'b0},
    {5'd1,  8'h80, 8'h01, 16'h0000, 8'h21, 8'h7F, 8'h00, 8'h69, 1'b0},
    {5'd2,  8'h10, 8'h20, 16'h0000, 8'h48, 8'h10, 8'h00, 8'hC8, 1'b0},
    {5'd3,  8'hF0, 8'h0F, 16'h0000, 8'h4D, 8'h00, 8'h00, 8'h4F, 1'b0},
    {5'd6,  8'h81, 8'h00, 16'h0000, 8'h00, 8'h02, 8'h00, 8'h01, 1'b0},
    {5'd8,  8'h40, 8'h00, 16'h0000, 8'h01, 8'h81, 8'h00, 8'h80, 1'b0},
    {5'd9,  8'h01, 8'h00, 16'h0000, 8'h00, 8'h00, 8'h00, 8'h03, 1'b0},
    {5'd10, 8'hA5, 8'h00, 16'h0000, 8'h00, 8'h5A, 8'h00, 8'h00, 1'b0},
    {5'd11, 8'hFF, 8'h00, 16'h0000, 8'h01, 8'h00, 8'h00, 8'h03, 1'b0},
    {5'd13, 8'h01, 8'h00, 16'h7FFF, 8'h00, 8'h00, 8'h80, 8'hC0, 1'b0},
    {5'd14, 8'h01, 8'h00, 16'h0000, 8'h01, 8'hFF, 8'hFF, 8'h80, 1'b0},
    {5'd18, 8'h00, 8'hFF, 16'h00FF, 8'h00, 8'h01, 8'hFE, 8'h80, 1'b0},
    {5'd19, 8'h00, 8'h07, 16'h0064, 8'h00, 8'h0E, 8'h02, 8'h00, 1'b0},
    {5'd19, 8'h00, 8'h00, 16'h1234, 8'hFF, 8'h34, 8'h12, 8'hFF, 1'b1},
    {5'd17, 8'h00, 8'h00, 16'h0001, 8'h41, 8'h00, 8'h00, 8'h43, 1'b0},
    {5'd15, 8'h34, 8'h12, 16'h1234, 8'h00, 8'h34, 8'h12, 8'h03, 1'b0}
  };

  function automatic string req_of(int op);
    case (op)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3, 4, 5: return "R4";
      6, 7, 8, 9: return "R5";
      10: return "R6";
      11, 12: return "R7";
      13, 14, 15: return "R8";
      16, 17: return "R9";
      18: return "R10";
      default: return "R11";
    endcase
  endfunction

  // Width-generic reference model; returns {err, psw, hi, lo}.
  function automatic logic [24:0] model(int w, int op, int d, int s, int pr, logic [7:0] f);
    int m  = (1 << w) - 1;
    int wm = (1 << (2 * w)) - 1;
    int hb = w / 2;
    int lo = d, hi = 0, r, o, rr, a, nzv, nzw;
    int n = int'(f[7]), v = int'(f[6]), h = int'(f[3]), z = int'(f[1]), c = int'(f[0]);
    int err = 0, setnz = 1;
    logic [7:0] psw;
    nzw = w;
    nzv = 0;
    o = (s << w) | d;
    a = pr & m;
    case (op)
      0: begin r = d + s + c; lo = r & m; c = (r >> w) & 1;
               v = (((d ^ lo) & (s ^ lo)) >> (w - 1)) & 1; h = ((d ^ s ^ lo) >> hb) & 1; end
      1: begin r = d - s - (1 - c); lo = r & m; c = (r >= 0) ? 1 : 0;
               v = (((d ^ lo) & (d ^ s)) >> (w - 1)) & 1; h = ((d ^ s ^ lo) >> hb) & 1; end
      2: begin r = d - s; c = (r >= 0) ? 1 : 0; nzv = r & m; lo = d; end
      3: lo = d & s;
      4: lo = d | s;
      5: lo = d ^ s;
      6: begin c = (d >> (w - 1)) & 1; lo = (d << 1) & m; end
      7: begin c = d & 1; lo = d >> 1; end
      8: begin lo = ((d << 1) | c) & m; c = (d >> (w - 1)) & 1; end
      9: begin lo = (d >> 1) | (c << (w - 1)); c = d & 1; end
      10: lo = ((d << hb) | (d >> hb)) & m;
      11: lo = (d + 1) & m;
      12: lo = (d - 1) & m;
      13, 14, 15, 16, 17, 18: begin
        nzw = 2 * w;
        case (op)
          13: begin r = pr + o; rr = r & wm; c = (r >> (2 * w)) & 1;
                    v = (((pr ^ rr) & (o ^ rr)) >> (2 * w - 1)) & 1; end
          14: begin r = pr - o; rr = r & wm; c = (r >= 0) ? 1 : 0;
                    v = (((pr ^ rr) & (pr ^ o)) >> (2 * w - 1)) & 1; end
          15: begin r = pr - o; c = (r >= 0) ? 1 : 0; rr = pr; nzv = r & wm; end
          16: rr = (pr + 1) & wm;
          17: rr = (pr - 1) & wm;
          default: rr = a * s;
        endcase
        lo = rr & m; hi = rr >> w;
      end
      19: begin
        if (s == 0) begin err = 1; setnz = 0; lo = a; hi = pr >> w; end
        else begin lo = a / s; hi = a % s; end
      end
      default: begin setnz = 0; lo = d; end
    endcase
    if (op != 2 && op != 15) nzv = (nzw == w) ? lo : ((hi << w) | lo);
    if (setnz == 1) begin
      n = (nzv >> (nzw - 1)) & 1;
      z = (nzv == 0) ? 1 : 0;
    end
    psw = {1'(n), 1'(v), f[5], f[4], 1'(h), f[2], 1'(z), 1'(c)};
    return {1'(err), psw, 8'(hi), 8'(lo)};
  endfunction

  task automatic compare(string req, logic [24:0] act, logic [24:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got err=%0h psw=%02h hi=%02h lo=%02h, expected err=%0h psw=%02h hi=%02h lo=%02h",
               req, act[24], act[23:16], act[15:8], act[7:0], exp[24], exp[23:16], exp[15:8], exp[7:0]);
    end
  endtask

  task automatic run8(int op, int d, int s, int pr, logic [7:0] f);
    op8 = 5'(op); d8 = 8'(d); s8 = 8'(s); pr8 = 16'(pr); f8 = f; st8 = 1'b1;
    @(posedge clk); @(negedge clk);
    st8 = 1'b0;
  endtask

  task automatic run4(int op, int d, int s, int pr, logic [7:0] f);
    op4 = 5'(op); d4 = 4'(d); s4 = 4'(s); pr4 = 8'(pr); f4 = f; st4 = 1'b1;
    @(posedge clk); @(negedge clk);
    st4 = 1'b0;
    compare(req_of(op), {e4, p4, 4'h0, hi4, 4'h0, lo4}, model(4, op, d, s, pr, f));
  endtask

  task automatic rand8(int op);
    int d  = int'($urandom_range(255));
    int s  = int'($urandom_range(255));
    int pr = int'($urandom_range(65535));
    logic [7:0] f = 8'($urandom);
    run8(op, d, s, pr, f);
    compare(req_of(op), {e8, p8, hi8, lo8}, model(8, op, d, s, pr, f));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] hl, hh, hp;
    rst_n = 1'b0;
    st8 = 1'b0; op8 = '0; d8 = '0; s8 = '0; pr8 = '0; f8 = '0;
    st4 = 1'b0; op4 = '0; d4 = '0; s4 = '0; pr4 = '0; f4 = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R14: reset state of both copies
    compare("R14", {v8, e8, p8, hi8, lo8[6:0]}, 25'd0);
    checks++;
    if (lo8[7] !== 1'b0 || v4 !== 1'b0 || lo4 !== 4'h0 || hi4 !== 4'h0 || p4 !== 8'h00 || e4 !== 1'b0) begin
      fails++;
      $display("FAIL R14: got narrow valid=%0b lo=%h hi=%h psw=%h err=%0b, expected all zero",
               v4, lo4, hi4, p4, e4);
    end

    // Vector table
    for (int i = 0; i < NV; i++) begin
      run8(int'(VEC[i][69:65]), int'(VEC[i][64:57]), int'(VEC[i][56:49]),
           int'(VEC[i][48:33]), VEC[i][32:25]);
      compare(req_of(int'(VEC[i][69:65])), {e8, p8, hi8, lo8},
              {VEC[i][0], VEC[i][8:1], VEC[i][16:9], VEC[i][24:17]});
    end

    // R12: valid for exactly one cycle, outputs held while idle
    run8(0, 8'h12, 8'h34, 0, 8'h00);
    hl = lo8; hh = hi8; hp = p8;
    checks++;
    if (v8 !== 1'b1) begin
      fails++; $display("FAIL R12: got valid=%0b, expected 1 after start", v8);
    end
    @(posedge clk); @(negedge clk);
    checks++;
    if (v8 !== 1'b0 || lo8 !== hl || hi8 !== hh || p8 !== hp) begin
      fails++;
      $display("FAIL R12: got valid=%0b lo=%h hi=%h psw=%h, expected 0 %h %h %h", v8, lo8, hi8, p8, hl, hh, hp);
    end

    // R13: P, B and I pass through on a logic op
    run8(3, 8'hFF, 8'hFF, 0, 8'h34);
    checks++;
    if (p8 !== 8'hB4) begin
      fails++; $display("FAIL R13: got psw=%h, expected b4", p8);
    end

    // Narrow copy: every operand pair with both carry values
    foreach (VEC[k]) begin end
    for (int op = 0; op < 20; op++) begin
      if (op >= 13 && op <= 17) begin
        for (int t = 0; t < 400; t++)
          run4(op, int'($urandom_range(15)), int'($urandom_range(15)),
               int'($urandom_range(255)), 8'($urandom));
      end else begin
        for (int d = 0; d < 16; d++)
          for (int s = 0; s < 16; s++)
            for (int c = 0; c < 2; c++)
              run4(op, d, s, (int'($urandom_range(15)) << 4) | d,
                   (8'($urandom) & 8'hFE) | 8'(c));
      end
    end

    // Wide copy: random operands for every operation
    for (int op = 0; op < 20; op++)
      for (int t = 0; t < 1500; t++)
        rand8(op);

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule